// File: doc/BRIEF.md
# Segmented Current-Cell Switch Decoder

This block turns a 12-bit unsigned converter code into the switch-enable word for a segmented current-cell array. The top four code bits pass straight through as binary-weighted enables. The middle four bits and the low four bits each drive their own sixteen-position unit-cell group, arranged as a 4x4 grid. Both groups use thermometer coding, so a group holding value v has exactly v unit cells switched on.

Cells in a group are not switched on in index order. A fixed sixteen-step walk picks each next cell. Each pair of consecutive steps takes two grid positions that mirror each other through the array centre, and the pairs move around the four quadrants. Any linear gradient across the grid therefore cancels after every second step, and the accumulated error swings about zero rather than drifting in one direction. Grid positions are numbered row*4+column, from 0 to 15. The walk visits positions 5, 10, 6, 9, 0, 15, 3, 12, 1, 14, 7, 8, 4, 11, 2, 13 in that order. The final position, 13, is a spare cell that is never switched on.

Codes enter on a valid/ready stream and leave on a registered valid/ready stream with one cycle of latency. While a result is waiting and the consumer holds `dn_ready` low, the result stays stable and `up_ready` is low. The upstream side then has to hold its code until `up_ready` returns high. Reset is synchronous and active high.

Top module: `seg_dac_decoder`

## Requirements
- R1: When a code is accepted (`up_valid` and `up_ready` high at a rising edge), `dn_bin` equals code bits [11:8] from the next cycle on.
- R2: The number of set bits in `dn_mid` equals code bits [7:4], and the number of set bits in `dn_low` equals code bits [3:0].
- R3: In both thermometer groups, grid bit p is set exactly when the rank of p in the walk order (5, 10, 6, 9, 0, 15, 3, 12, 1, 14, 7, 8, 4, 11, 2, 13; rank 0 is first) is less than that group's segment value.
- R4: Grid bit 13 of `dn_mid` and of `dn_low` is never set.
- R5: When the accepted code is exactly one more than the previously accepted code, exactly one cell toggles in the thermometer group that the increment reaches.
- R6: An accepted code raises `dn_valid` on the next rising edge, carrying that code's enables.
- R7: While `dn_valid` is high and `dn_ready` is low, `up_ready` is low, and `dn_valid` and all enable outputs stay unchanged. `up_ready` equals `!dn_valid || dn_ready` at all times.
- R8: A synchronous reset clears `dn_valid` and every enable bit, which matches code 0.
- R9: When a group's segment value is even, its enables are point-symmetric: bit p equals bit 15-p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| up_valid | input | 1 | Input code present |
| up_ready | output | 1 | Block can accept a code this cycle |
| up_code | input | 12 | Unsigned converter code |
| dn_valid | output | 1 | Registered enables are valid |
| dn_ready | input | 1 | Consumer takes the enables |
| dn_bin | output | 4 | Binary-weighted cell enables (code bits [11:8]) |
| dn_mid | output | 16 | Middle-group grid enables, bit index = row*4+column |
| dn_low | output | 16 | Low-group grid enables, bit index = row*4+column |

## Verification
A wrong entry in the walk table shows up at once as a wrong grid bit in the cycle after the affected segment value is accepted. With a mirror error, it also breaks the point symmetry for even values. A rank comparison that is off by one changes the count of enabled cells, so the error is visible in the first cycle that presents a segment value at the boundary. A flaw in the hold logic shows up as enables changing, or a code being lost, during the first stalled cycle. The bench compares every output against a behavioural model on every clock, so any of these faults is reported within one cycle of the stimulus that exposes it.

// File: rtl/dac_seg_pkg.sv
package dac_seg_pkg;
  localparam int SEG_W   = 4;
  localparam int N_SEG   = 3;
  localparam int CODE_W  = SEG_W * N_SEG;
  localparam int CELLS   = 1 << SEG_W;
  localparam int N_THERM = N_SEG - 1;
  localparam int OUT_W   = SEG_W + N_THERM * CELLS;

  // Grid position chosen at each step of the walk. Consecutive pairs mirror
  // through the grid centre (a + b == CELLS-1); the last step is the spare.
  function automatic logic [SEG_W-1:0] walk_pos(input logic [SEG_W-1:0] step);
    case (step)
      4'd0:    walk_pos = 4'd5;
      4'd1:    walk_pos = 4'd10;
      4'd2:    walk_pos = 4'd6;
      4'd3:    walk_pos = 4'd9;
      4'd4:    walk_pos = 4'd0;
      4'd5:    walk_pos = 4'd15;
      4'd6:    walk_pos = 4'd3;
      4'd7:    walk_pos = 4'd12;
      4'd8:    walk_pos = 4'd1;
      4'd9:    walk_pos = 4'd14;
      4'd10:   walk_pos = 4'd7;
      4'd11:   walk_pos = 4'd8;
      4'd12:   walk_pos = 4'd4;
      4'd13:   walk_pos = 4'd11;
      4'd14:   walk_pos = 4'd2;
      default: walk_pos = 4'd13;
    endcase
  endfunction

  // Inverse of the walk: step at which a grid position is switched on.
  function automatic logic [SEG_W-1:0] rank_of(input logic [SEG_W-1:0] pos);
    rank_of = '0;
    for (int s = 0; s < CELLS; s++) begin
      if (walk_pos(SEG_W'(s)) == pos) rank_of = SEG_W'(s);
    end
  endfunction
endpackage

// File: rtl/dac_therm_walk.sv
module dac_therm_walk
  import dac_seg_pkg::*;
(
  input  logic [SEG_W-1:0] seg,
  output logic [CELLS-1:0] en
);
  // Each grid position turns on once the segment value passes its walk rank.
  for (genvar p = 0; p < CELLS; p++) begin : g_cell
    localparam logic [SEG_W-1:0] RANK = rank_of(SEG_W'(p));
    assign en[p] = (RANK < seg);
  end

  always_comb begin
    AST_THERM_COUNT: assert ($countones(en) == int'(seg)); // R2
  end
endmodule

// File: rtl/dac_out_stage.sv
module dac_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data)); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && out_data == '0); // R8
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder
  import dac_seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [CODE_W-1:0] up_code,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [SEG_W-1:0]  dn_bin,
  output logic [CELLS-1:0]  dn_mid,
  output logic [CELLS-1:0]  dn_low
);
  logic [N_THERM-1:0][CELLS-1:0] therm;
  logic [OUT_W-1:0]              word_d;
  logic [OUT_W-1:0]              word_q;

  // Group 0 decodes the low nibble, group 1 the middle nibble.
  for (genvar g = 0; g < N_THERM; g++) begin : g_grp
    dac_therm_walk u_walk (
      .seg (up_code[g*SEG_W +: SEG_W]),
      .en  (therm[g])
    );
  end

  assign word_d = {up_code[CODE_W-1 -: SEG_W], therm[1], therm[0]};

  dac_out_stage #(.W(OUT_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (up_valid),
    .in_ready  (up_ready),
    .in_data   (word_d),
    .out_valid (dn_valid),
    .out_ready (dn_ready),
    .out_data  (word_q)
  );

  assign dn_bin = word_q[OUT_W-1 -: SEG_W];
  assign dn_mid = word_q[2*CELLS-1 -: CELLS];
  assign dn_low = word_q[CELLS-1:0];

  AST_BIN_PASS: assert property (@(posedge clk) disable iff (rst)
    up_valid && up_ready |=> dn_bin == $past(up_code[CODE_W-1 -: SEG_W])); // R1
endmodule

// File: tb/seg_dac_decoder_bench.sv
module seg_dac_decoder_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        up_valid;
  logic        up_ready;
  logic [11:0] up_code;
  logic        dn_valid;
  logic        dn_ready;
  logic [3:0]  dn_bin;
  logic [15:0] dn_mid;
  logic [15:0] dn_low;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference model state
  bit      m_valid = 1'b0;
  int      m_code = 0;
  bit      m_loaded = 1'b0;
  int      prev_code = -1;
  logic [15:0] prev_mid = '0;
  logic [15:0] prev_low = '0;
  int      order [16] = '{5, 10, 6, 9, 0, 15, 3, 12, 1, 14, 7, 8, 4, 11, 2, 13};

  always #10 clk = ~clk;

  seg_dac_decoder u_seg_dac_decoder (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready),
    .up_code(up_code), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_bin(dn_bin), .dn_mid(dn_mid), .dn_low(dn_low)
  );

  function automatic logic [15:0] cells(input int v);
    logic [15:0] r = '0;
    for (int s = 0; s < v; s++) r[order[s]] = 1'b1;
    return r;
  endfunction

  function automatic bit mirrored(input logic [15:0] e);
    for (int p = 0; p < 16; p++) if (e[p] != e[15-p]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: model update at the edge, compare at the falling edge.
  task automatic cyc();
    @(posedge clk);
    m_loaded = 1'b0;
    if (rst) begin
      m_valid = 1'b0;
      m_code = 0;
    end else if (up_valid && (!m_valid || dn_ready)) begin
      m_valid = 1'b1;
      m_code = int'(up_code);
      m_loaded = 1'b1;
    end else if (dn_ready) begin
      m_valid = 1'b0;
    end
    @(negedge clk);
    chk(dn_valid == m_valid, "R6 dn_valid", 64'(dn_valid), 64'(m_valid));
    chk(up_ready == (!m_valid || dn_ready), "R7 up_ready", 64'(up_ready), 64'(!m_valid || dn_ready));
    chk(dn_bin == 4'(m_code >> 8), "R1 dn_bin", 64'(dn_bin), 64'(m_code >> 8));
    chk(dn_mid == cells((m_code >> 4) & 15), "R3 dn_mid", 64'(dn_mid), 64'(cells((m_code >> 4) & 15)));
    chk(dn_low == cells(m_code & 15), "R3 dn_low", 64'(dn_low), 64'(cells(m_code & 15)));
    chk($countones(dn_mid) == ((m_code >> 4) & 15), "R2 mid count", 64'($countones(dn_mid)), 64'((m_code >> 4) & 15));
    chk($countones(dn_low) == (m_code & 15), "R2 low count", 64'($countones(dn_low)), 64'(m_code & 15));
    chk(!dn_mid[13] && !dn_low[13], "R4 spare cell", {dn_mid[13], dn_low[13]}, 64'd0);
    if ((m_code & 1) == 0)
      chk(mirrored(dn_low), "R9 low symmetry", 64'(dn_low), 64'(cells(m_code & 15)));
    if (((m_code >> 4) & 1) == 0)
      chk(mirrored(dn_mid), "R9 mid symmetry", 64'(dn_mid), 64'(cells((m_code >> 4) & 15)));
    if (m_loaded) begin
      if (prev_code >= 0 && m_code == prev_code + 1) begin
        if ((m_code & 15) != 0)
          chk($countones(dn_low ^ prev_low) == 1, "R5 low step", 64'(dn_low ^ prev_low), 64'd1);
        else if (((m_code >> 4) & 15) != 0)
          chk($countones(dn_mid ^ prev_mid) == 1, "R5 mid step", 64'(dn_mid ^ prev_mid), 64'd1);
      end
      prev_code = m_code;
      prev_mid = dn_mid;
      prev_low = dn_low;
    end
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    rst = 1'b1; up_valid = 1'b0; up_code = '0; dn_ready = 1'b1;
    repeat (3) cyc();
    chk(!dn_valid && dn_mid == '0 && dn_low == '0 && dn_bin == '0, "R8 reset state",
        {dn_valid, dn_bin, dn_mid, dn_low}, 64'd0);
    rst = 1'b0;
    // Full ascending sweep, one code per cycle, no back-pressure.
    for (int c = 0; c < 4096; c++) begin
      up_valid = 1'b1; up_code = 12'(c);
      cyc();
    end
    up_valid = 1'b0;
    cyc();
    // Irregular traffic with back-pressure; codes held while stalled.
    up_code = 12'h5A3;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dn_ready = lfsr[0] | lfsr[3];
      if (!up_valid || up_ready) begin
        up_valid = lfsr[5] | lfsr[7];
        up_code = lfsr[11:0] ^ lfsr[15:4];
      end
      cyc();
    end
    // Long stall with a pending result, then a reset while full.
    up_valid = 1'b1; up_code = 12'hFFF; dn_ready = 1'b1;
    cyc();
    dn_ready = 1'b0; up_code = 12'h000;
    repeat (5) cyc();
    rst = 1'b1;
    cyc();
    chk(!dn_valid && dn_mid == '0 && dn_low == '0, "R8 reset while full",
        {dn_valid, dn_mid, dn_low}, 64'd0);
    rst = 1'b0; up_valid = 1'b0; dn_ready = 1'b1;
    cyc();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule